// File: doc/BRIEF.md
# Skewer Projection Extrema Array

This block finds, for each of a set of fixed projection directions ("skewers"), which spectral pixel vectors project farthest in the positive and in the negative direction. It is a two-dimensional output-stationary systolic grid of NSKW rows by NPIX columns. Each column handles one pixel of the current block. Each row handles one skewer. Every cell keeps one dot product in place, so no pixel value is ever broadcast to the whole grid.

Each input beat carries one spectral band of all NPIX pixels of a block, together with the same band of all NSKW skewers. Internal delay lines skew the streams. Pixel components then descend one row per clock and skewer components advance one column per clock, so that matching components meet in the right cell. When a cell finishes its dot product, it merges its result into a candidate record that moves rightward along its row. That record holds the block's largest and smallest projections with their column numbers. At the right edge, one extreme node per skewer folds each block's record into a running maximum and minimum, with global pixel indices, across all blocks of the sequence.

A start pulse opens a sequence. The block marked final closes it. When the final block has drained, a one-cycle done pulse is raised, and at that point the outputs hold the answer.

Top module: `skewer_extrema_array`

## Requirements
- R1: After reset, `done` is low and every value and index output reads zero.
- R2: A block is exactly NBAND beats with `in_vld` high, and `in_last` is high on the final beat. For each skewer row k, `max_val[k*40 +: 40]` is the largest signed dot product over all pixels of the sequence. Here pixel column p is `pix_data[p*16 +: 16]` and skewer row k is `skw_data[k*16 +: 16]`, all two's complement. `max_idx[k*16 +: 16]` is that pixel's global index.
- R3: For each skewer row k, `min_val[k*40 +: 40]` and `min_idx[k*16 +: 16]` give the smallest signed dot product and its global index.
- R4: When projections are equal, the pixel with the lower global index is reported, both inside a block and across blocks.
- R5: Blocks of a sequence are numbered from 0. A pixel's global index is block number times NPIX plus its column. The extremes run over all blocks, which may follow one another with no idle beat.
- R6: Beats with `in_vld` low, inside a block or between blocks, leave every result unchanged.
- R7: `done` is high for exactly one cycle. It rises NPIX+NSKW-1 clock edges after the edge that accepts the last beat of the block flagged by `in_final`, with all outputs valid in that cycle. Non-final blocks raise no `done`.
- R8: A `start` pulse clears all sums, extremes and block numbering. In the cycle after it, `done` is low and every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a sequence, clears all state |
| in_vld | input | 1 | Beat carries one band of pixels and skewers |
| in_last | input | 1 | Beat is the final band of a block |
| in_final | input | 1 | Block is the final one of the sequence (read with in_last) |
| pix_data | input | NPIX*16 | One band of every pixel of the block |
| skw_data | input | NSKW*16 | Same band of every skewer |
| max_val | output | NSKW*40 | Largest projection per skewer |
| max_idx | output | NSKW*16 | Global index of that pixel |
| min_val | output | NSKW*40 | Smallest projection per skewer |
| min_idx | output | NSKW*16 | Global index of that pixel |
| done | output | 1 | One-cycle pulse when the sequence result is ready |

## Verification
Two functions can land in the same cycle. While the extreme nodes merge the candidate records of one block, the cells are already accumulating the next block. The bench provokes this by sending blocks back-to-back with no idle beat, and also with bubbles inserted. A scoreboard model computes every dot product and the tie-broken extremes independently, and it predicts the exact cycle of `done`. A separate tie sequence, in which every pixel is identical, shows whether merges across a block boundary keep the earlier index.

// File: rtl/skp_pkg.sv
// Shared widths and record types for the skewer projection extrema array.
// Assumes two's complement components and an accumulator wide enough for NBAND products.
package skp_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ACC_W  = 40;
    localparam int unsigned IDX_W  = 16;

    typedef logic signed [DATA_W-1:0] comp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [IDX_W-1:0]         idx_t;

    // One pixel component with the flags that travel beside it.
    typedef struct packed {
        logic  vld;
        logic  last;
        logic  fin;
        comp_t d;
    } pix_t;

    // Candidate record passed rightward along a skewer row.
    typedef struct packed {
        logic vld;
        logic fin;
        acc_t hi;
        idx_t hi_i;
        acc_t lo;
        idx_t lo_i;
    } tok_t;
endpackage

// File: rtl/skp_tapline.sv
// Delay line with NTAP consecutive taps, the first one OFFSET registers after the input.
// A tap at offset 0 is the input itself. Assumes OFFSET+NTAP-1 >= 1.
module skp_tapline #(
    parameter int unsigned W      = 16,
    parameter int unsigned OFFSET = 1,
    parameter int unsigned NTAP   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] tap [NTAP]
);
    localparam int unsigned DEPTH = OFFSET + NTAP - 1;

    logic [W-1:0] stage_q [1:DEPTH];

    // Shift the delay stages, clearing them on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 1; i <= DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[1] <= din;
            for (int i = 2; i <= DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    for (genvar j = 0; j < NTAP; j++) begin : g_tap
        if (OFFSET + j == 0) begin : g_direct
            assign tap[j] = din;
        end else begin : g_reg
            assign tap[j] = stage_q[OFFSET + j];
        end
    end
endmodule

// File: rtl/skp_cell.sv
// Dot-product cell: keeps a stationary partial sum and, on the last band,
// merges its finished projection into the row's candidate record.
// Assumes the incoming record from the left arrives in the same cycle as the last band.
module skp_cell
    import skp_pkg::*;
#(
    parameter int unsigned COL = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  pix_t  pin,
    input  comp_t sin,
    input  tok_t  tin,
    output tok_t  tout
);
    logic signed [2*DATA_W-1:0] prod;
    acc_t acc_q;
    acc_t sum;
    tok_t cand;

    // Product of the meeting components and the running sum including it.
    always_comb begin
        prod = $signed(pin.d) * $signed(sin);
        sum  = acc_q + acc_t'(prod);
    end

    // Merge this column's result into the record from the left; equal values keep the left one.
    always_comb begin
        cand      = '0;
        cand.vld  = pin.vld && pin.last;
        cand.fin  = pin.fin;
        if (tin.vld && !($signed(sum) > $signed(tin.hi))) begin
            cand.hi   = tin.hi;
            cand.hi_i = tin.hi_i;
        end else begin
            cand.hi   = sum;
            cand.hi_i = idx_t'(COL);
        end
        if (tin.vld && !($signed(sum) < $signed(tin.lo))) begin
            cand.lo   = tin.lo;
            cand.lo_i = tin.lo_i;
        end else begin
            cand.lo   = sum;
            cand.lo_i = idx_t'(COL);
        end
    end

    // Accumulate on valid beats, restart after the last band, register the record.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            tout  <= '0;
        end else begin
            tout <= cand;
            if (pin.vld) acc_q <= pin.last ? acc_t'(0) : sum;
        end
    end

    if (COL > 0) begin : g_chk
        AST_TOKEN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (pin.vld && pin.last) |-> tin.vld) else $error("record from left missing"); // R2
    end
endmodule

// File: rtl/skp_extreme.sv
// Per-skewer extreme node: folds each block's candidate record into the running
// maximum and minimum with global pixel indices. Equal values keep the earlier index.
module skp_extreme
    import skp_pkg::*;
#(
    parameter int unsigned NPIX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  tok_t tin,
    output acc_t hi,
    output idx_t hi_i,
    output acc_t lo,
    output idx_t lo_i,
    output logic fin_hit
);
    localparam int unsigned MAX_BLK = (1 << IDX_W) / NPIX;

    acc_t hi_q, lo_q;
    idx_t hi_i_q, lo_i_q, blk_q, base;
    logic have_q;

    // Global index base of the block now arriving.
    always_comb base = idx_t'(blk_q * idx_t'(NPIX));

    // Fold the arriving record into the running extremes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q   <= '0;
            hi_i_q <= '0;
            lo_q   <= '0;
            lo_i_q <= '0;
            blk_q  <= '0;
            have_q <= 1'b0;
        end else if (tin.vld) begin
            have_q <= 1'b1;
            blk_q  <= blk_q + idx_t'(1);
            if (!have_q || ($signed(tin.hi) > $signed(hi_q))) begin
                hi_q   <= tin.hi;
                hi_i_q <= base + tin.hi_i;
            end
            if (!have_q || ($signed(tin.lo) < $signed(lo_q))) begin
                lo_q   <= tin.lo;
                lo_i_q <= base + tin.lo_i;
            end
        end
    end

    // Final block of the sequence is being merged this cycle.
    always_comb fin_hit = tin.vld && tin.fin;

    assign hi   = hi_q;
    assign hi_i = hi_i_q;
    assign lo   = lo_q;
    assign lo_i = lo_i_q;

    AST_MAX_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && !clr) |=> ($signed(hi_q) >= $signed($past(hi_q)))) else $error("max fell"); // R2
    AST_MIN_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && !clr) |=> ($signed(lo_q) <= $signed($past(lo_q)))) else $error("min rose"); // R3
    AST_INDEX_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tin.vld |-> (32'(blk_q) < MAX_BLK)) else $error("block index wraps"); // R5
endmodule

// File: rtl/skewer_extrema_array.sv
// Top of the skewer projection extrema array: NSKW skewer rows by NPIX pixel columns.
// Skews both input streams, runs the cell grid, and collects per-skewer extremes.
// Assumes NPIX >= 2, NSKW >= 2, and a block of exactly NBAND valid beats ending with in_last.
module skewer_extrema_array
    import skp_pkg::*;
#(
    parameter int unsigned NPIX  = 4,
    parameter int unsigned NSKW  = 3,
    parameter int unsigned NBAND = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_vld,
    input  logic                     in_last,
    input  logic                     in_final,
    input  logic [NPIX*DATA_W-1:0]   pix_data,
    input  logic [NSKW*DATA_W-1:0]   skw_data,
    output logic [NSKW*ACC_W-1:0]    max_val,
    output logic [NSKW*IDX_W-1:0]    max_idx,
    output logic [NSKW*ACC_W-1:0]    min_val,
    output logic [NSKW*IDX_W-1:0]    min_idx,
    output logic                     done
);
    localparam int unsigned PW    = $bits(pix_t);
    localparam int unsigned BCNTW = $clog2(NBAND) + 1;

    logic [PW-1:0]     pcol [NPIX][NSKW];
    logic [DATA_W-1:0] srow [NSKW][NPIX];
    tok_t              tg   [NSKW][NPIX+1];
    logic [NSKW-1:0]   fin_hit;
    logic [NSKW-1:0]   seen_q;
    logic              done_q;
    logic [BCNTW-1:0]  band_q;

    // Pixel columns: column p enters the grid p cycles late, then descends one row per clock.
    for (genvar p = 0; p < NPIX; p++) begin : g_col
        pix_t src;
        assign src.vld  = in_vld;
        assign src.last = in_last;
        assign src.fin  = in_final;
        assign src.d    = pix_data[p*DATA_W +: DATA_W];
        skp_tapline #(.W(PW), .OFFSET(p), .NTAP(NSKW)) u_pdl (
            .clk(clk), .rst_n(rst_n), .clr(start), .din(src), .tap(pcol[p])
        );
    end

    // Skewer rows: row k enters k cycles late, then advances one column per clock.
    for (genvar k = 0; k < NSKW; k++) begin : g_row
        skp_tapline #(.W(DATA_W), .OFFSET(k), .NTAP(NPIX)) u_sdl (
            .clk(clk), .rst_n(rst_n), .clr(start),
            .din(skw_data[k*DATA_W +: DATA_W]), .tap(srow[k])
        );

        assign tg[k][0] = '0;

        for (genvar p = 0; p < NPIX; p++) begin : g_cell
            skp_cell #(.COL(p)) u_cell (
                .clk(clk), .rst_n(rst_n), .clr(start),
                .pin(pix_t'(pcol[p][k])), .sin(comp_t'(srow[k][p])),
                .tin(tg[k][p]), .tout(tg[k][p+1])
            );
        end

        acc_t hi_w, lo_w;
        idx_t hi_i_w, lo_i_w;
        skp_extreme #(.NPIX(NPIX)) u_ext (
            .clk(clk), .rst_n(rst_n), .clr(start), .tin(tg[k][NPIX]),
            .hi(hi_w), .hi_i(hi_i_w), .lo(lo_w), .lo_i(lo_i_w), .fin_hit(fin_hit[k])
        );
        assign max_val[k*ACC_W +: ACC_W] = hi_w;
        assign max_idx[k*IDX_W +: IDX_W] = hi_i_w;
        assign min_val[k*ACC_W +: ACC_W] = lo_w;
        assign min_idx[k*IDX_W +: IDX_W] = lo_i_w;
    end

    // Raise done once every skewer row has merged the final block.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            seen_q <= '0;
            done_q <= 1'b0;
        end else begin
            seen_q <= seen_q | fin_hit;
            done_q <= (&(seen_q | fin_hit)) && !(&seen_q);
        end
    end

    // Count valid beats within a block to police the input framing.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            band_q <= '0;
        end else if (in_vld) begin
            band_q <= in_last ? '0 : band_q + BCNTW'(1);
        end
    end

    assign done = done_q;

    AST_BLOCK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n || start)
        (in_vld && in_last) |-> (32'(band_q) == NBAND - 1)) else $error("short or long block"); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && max_val == '0 && min_val == '0 && max_idx == '0 && min_idx == '0))
        else $error("start left state"); // R8
endmodule

// File: tb/sim_skewer_extrema_array.sv
`timescale 1ns/1ps
module sim_skewer_extrema_array;
    localparam int NPIX = 4;
    localparam int NSKW = 3;
    localparam int NBAND = 5;
    localparam int DW = 16;
    localparam int AW = 40;
    localparam int IW = 16;
    localparam int MAXB = 4;

    typedef struct packed {
        int unsigned              cyc;
        logic [NSKW*AW-1:0]       mx;
        logic [NSKW*IW-1:0]       mxi;
        logic [NSKW*AW-1:0]       mn;
        logic [NSKW*IW-1:0]       mni;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_vld = 1'b0, in_last = 1'b0, in_final = 1'b0;
    logic [NPIX*DW-1:0] pix_data = '0;
    logic [NSKW*DW-1:0] skw_data = '0;
    logic [NSKW*AW-1:0] max_val, min_val;
    logic [NSKW*IW-1:0] max_idx, min_idx;
    logic done;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'h1234_5678;
    string cur_tag = "";
    logic prev_done = 1'b0;
    exp_t expq [$];

    int pixv [MAXB][NPIX][NBAND];
    int skwv [NSKW][NBAND];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    skewer_extrema_array #(.NPIX(NPIX), .NSKW(NSKW), .NBAND(NBAND)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_vld(in_vld), .in_last(in_last),
        .in_final(in_final), .pix_data(pix_data), .skw_data(skw_data),
        .max_val(max_val), .max_idx(max_idx), .min_val(min_val), .min_idx(min_idx),
        .done(done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % 32'd4001) - 2000;
    endfunction

    // Driver: builds data, pushes the expected result, then streams the beats.
    task automatic run_seq(input int nblk, input bit gaps, input bit tie, input string tag);
        exp_t e;
        cur_tag = tag;
        for (int k = 0; k < NSKW; k++)
            for (int b = 0; b < NBAND; b++) skwv[k][b] = rnd();
        for (int bl = 0; bl < nblk; bl++)
            for (int p = 0; p < NPIX; p++)
                for (int b = 0; b < NBAND; b++)
                    pixv[bl][p][b] = (tie && (bl > 0 || p > 0)) ? pixv[0][0][b] : rnd();
        e = '0;
        for (int k = 0; k < NSKW; k++) begin
            longint hi = 0, lo = 0;
            int hii = 0, loi = 0;
            bit have = 0;
            for (int bl = 0; bl < nblk; bl++)
                for (int p = 0; p < NPIX; p++) begin
                    longint d = 0;
                    for (int b = 0; b < NBAND; b++) d += longint'(pixv[bl][p][b]) * longint'(skwv[k][b]);
                    if (!have || d > hi) begin hi = d; hii = bl * NPIX + p; end
                    if (!have || d < lo) begin lo = d; loi = bl * NPIX + p; end
                    have = 1;
                end
            e.mx[k*AW +: AW] = AW'(hi);
            e.mn[k*AW +: AW] = AW'(lo);
            e.mxi[k*IW +: IW] = IW'(hii);
            e.mni[k*IW +: IW] = IW'(loi);
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int bl = 0; bl < nblk; bl++)
            for (int b = 0; b < NBAND; b++) begin
                if (gaps && (b == 0 || b == 3)) begin
                    in_vld = 1'b0;
                    pix_data = '1;
                    skw_data = '1;
                    repeat (2) @(negedge clk);
                end
                in_vld = 1'b1;
                in_last = (b == NBAND - 1);
                in_final = (b == NBAND - 1) && (bl == nblk - 1);
                for (int p = 0; p < NPIX; p++) pix_data[p*DW +: DW] = DW'(pixv[bl][p][b]);
                for (int k = 0; k < NSKW; k++) skw_data[k*DW +: DW] = DW'(skwv[k][b]);
                if (in_final) begin
                    e.cyc = cyc + NPIX + NSKW;
                    expq.push_back(e);
                end
                @(negedge clk);
            end
        in_vld = 1'b0;
        in_last = 1'b0;
        in_final = 1'b0;
        while (expq.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every done pulse and compares all outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (prev_done) chk("R7 done longer than one cycle", 1, 0);
                if (expq.size() == 0) begin
                    chk("R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk({"R7 done cycle ", cur_tag}, longint'(cyc), longint'(e.cyc));
                    for (int k = 0; k < NSKW; k++) begin
                        chk({"R2 max value ", cur_tag}, longint'($signed(max_val[k*AW +: AW])),
                            longint'($signed(e.mx[k*AW +: AW])));
                        chk({"R2 max index ", cur_tag}, longint'(max_idx[k*IW +: IW]),
                            longint'(e.mxi[k*IW +: IW]));
                        chk({"R3 min value ", cur_tag}, longint'($signed(min_val[k*AW +: AW])),
                            longint'($signed(e.mn[k*AW +: AW])));
                        chk({"R3 min index ", cur_tag}, longint'(min_idx[k*IW +: IW]),
                            longint'(e.mni[k*IW +: IW]));
                    end
                end
            end
            prev_done = done;
        end
    end

    task automatic check_clear(input string tag);
        chk({tag, " done"}, longint'(done), 0);
        chk({tag, " max_val"}, longint'(|max_val), 0);
        chk({tag, " min_val"}, longint'(|min_val), 0);
        chk({tag, " max_idx"}, longint'(|max_idx), 0);
        chk({tag, " min_idx"}, longint'(|min_idx), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_clear("R1 reset");
        run_seq(1, 0, 0, "R2 single block");
        run_seq(3, 0, 0, "R5 back-to-back blocks");
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check_clear("R8 start clears");
        run_seq(2, 1, 0, "R6 bubbles");
        run_seq(2, 0, 1, "R4 ties");
        run_seq(4, 1, 0, "R5 four blocks with bubbles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8ns * 60000);
        errors++;
        checks++;
        $display("FAIL watchdog expired in %s", cur_tag);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule